// File: doc/BRIEF.md
# Privileged PC Flag Restore Unit

This unit holds the processor flag half-word and works out its next value whenever a jump instruction from the jump-family group is issued. Some of these jumps restore the flags from a half-word read from memory. For those, the unit applies asymmetric privilege rules to the user-mode, user-I/O and public bits. These rules stop code running in user mode from raising its own privilege. The remaining variants either leave the flags alone, clear the public bit, or ask for a halt.

The unit also checks privilege for the variants that dismiss an interrupt and for the halt variant. It raises an illegal-operation pulse for any variant code that is not implemented. When section loading is enabled and the restored flags select exec mode, it strobes a previous-context-section value taken from the right half-word. All results are registered and appear one cycle after the start strobe. Updating the program counter is left to the surrounding datapath.

Flag bit positions in the 18-bit half-word: user mode is bit 12, user-I/O is bit 11 and public is bit 10. The implemented flags are bits 17 to 5. The section field is bits 4 to 0 of the right half.

Top module: `flag_restore_unit`

## Requirements
- R1: While reset is active, and until the first start strobe after it, `flags` is 0 (exec mode, public clear) and `sect_load`, `muuo` and `halt_req` are 0.
- R2: Every result appears in the cycle after `start`. `sect_load`, `muuo` and `halt_req` are one-cycle pulses. Without `start`, `flags` holds its value and the pulses stay 0.
- R3: On a flag restore (variant codes 2, 5, 6, 7, 10) taken while bit 12 is set, the new bit 12 is 1 whatever `new_lh` holds. From exec mode, a 1 in `new_lh` bit 12 sets it.
- R4: On a restore in user mode with bit 11 clear, the new bit 11 is 0. With bit 11 already set, bit 11 follows `new_lh`. A 0 always clears it.
- R5: On a restore, a 1 in `new_lh` bit 10 always sets bit 10. Clearing a set bit 10 takes effect only when the old mode is exec and the new bit 12 is 1. Otherwise bit 10 stays 1.
- R6: Restored flags are masked to the implemented bits 17..5, so bits 4..0 of `flags` read 0.
- R7: When a legal restore has `sect_en` set and its new bit 12 is 0, `sect_load` pulses and `sect_val` equals `new_rh` & 0x1F. Otherwise `sect_load` stays 0.
- R8: The interrupt-dismiss codes 6, 7, 8 and 10 are illegal in two cases: user mode with bit 11 clear, and exec mode with bit 10 set. An illegal variant pulses `muuo` and leaves `flags` unchanged.
- R9: Halt (code 4) pulses `halt_req` only when bits 12 and 10 are both 0. Otherwise it pulses `muuo`. Neither case changes `flags`.
- R10: Codes 3, 9, 11, 14 and 15 pulse `muuo` and leave `flags` unchanged.
- R11: Code 1 clears bit 10 and keeps every other flag. Codes 0, 12 and 13 leave `flags` unchanged and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe for one jump variant |
| op | input | 4 | Jump variant code |
| new_lh | input | 18 | Proposed flag half-word from memory |
| new_rh | input | 18 | Right half-word carrying the section field |
| sect_en | input | 1 | Section loading applies to this restore |
| flags | output | 18 | Current flag half-word |
| sect_load | output | 1 | Section-load strobe |
| sect_val | output | 18 | Masked section value |
| muuo | output | 1 | Illegal or unimplemented operation pulse |
| halt_req | output | 1 | Halt request pulse |

## Verification
Each outcome is due exactly one clock edge after the cycle in which `start` is high. The flag word changes at that edge, and each pulse is valid for that one cycle only. The bench raises `start` at a falling edge and drops it at the next falling edge. It then samples every output at that same falling edge, which lies half a period after the edge that registered the result. Hold checks sample again after several idle cycles to confirm that the flags have not moved and that no pulse has reappeared.

// File: rtl/flag_restore_pkg.sv
package flag_restore_pkg;
    localparam int HW          = 18;
    localparam int BIT_USER    = 12;
    localparam int BIT_UIO     = 11;
    localparam int BIT_PUB     = 10;
    localparam logic [HW-1:0] IMPL_MASK = 18'h3FFE0;
    localparam logic [HW-1:0] SECT_MASK = 18'h0001F;

    typedef enum logic [3:0] {
        V_JUMP    = 4'd0,
        V_PORTAL  = 4'd1,
        V_RESTORE = 4'd2,
        V_HALT    = 4'd4,
        V_RESTX   = 4'd5,
        V_DISRX   = 4'd6,
        V_SWAPPC  = 4'd7,
        V_DISMISS = 4'd8,
        V_DISRST  = 4'd10,
        V_SAVEFL  = 4'd12,
        V_INDJUMP = 4'd13
    } variant_e;

    typedef struct packed {
        logic [HW-1:0] flags;
        logic          sect_load;
        logic [HW-1:0] sect_val;
        logic          muuo;
        logic          halt_req;
    } unit_state_t;
endpackage

// File: rtl/flag_merge.sv
module flag_merge
    import flag_restore_pkg::*;
(
    input  logic [HW-1:0] cur,
    input  logic [HW-1:0] proposed,
    output logic [HW-1:0] merged
);
    logic [HW-1:0] nf;

    always_comb begin
        nf = proposed;
        if (cur[BIT_USER]) begin
            nf[BIT_USER] = 1'b1;
            if (!cur[BIT_UIO]) begin
                nf[BIT_UIO] = 1'b0;
            end
        end
        if (cur[BIT_PUB] && !nf[BIT_PUB]) begin
            if (cur[BIT_USER] || !nf[BIT_USER]) begin
                nf[BIT_PUB] = 1'b1;
            end
        end
        merged = nf & IMPL_MASK;
    end
endmodule

// File: rtl/variant_decode.sv
module variant_decode
    import flag_restore_pkg::*;
(
    input  logic [3:0] op,
    input  logic       cur_user,
    input  logic       cur_uio,
    input  logic       cur_pub,
    output logic       do_restore,
    output logic       do_clr_pub,
    output logic       do_halt,
    output logic       illegal
);
    logic dismiss_ok;
    logic halt_ok;

    assign dismiss_ok = !((cur_user && !cur_uio) || (!cur_user && cur_pub));
    assign halt_ok    = !cur_user && !cur_pub;

    always_comb begin
        do_restore = 1'b0;
        do_clr_pub = 1'b0;
        do_halt    = 1'b0;
        illegal    = 1'b0;
        case (op)
            V_JUMP, V_SAVEFL, V_INDJUMP: ;
            V_PORTAL:          do_clr_pub = 1'b1;
            V_RESTORE, V_RESTX: do_restore = 1'b1;
            V_HALT: begin
                do_halt = halt_ok;
                illegal = !halt_ok;
            end
            V_DISRX, V_SWAPPC, V_DISRST: begin
                do_restore = dismiss_ok;
                illegal    = !dismiss_ok;
            end
            V_DISMISS:         illegal = !dismiss_ok;
            default:           illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/flag_restore_unit.sv
module flag_restore_unit
    import flag_restore_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic [HW-1:0] new_lh,
    input  logic [HW-1:0] new_rh,
    input  logic          sect_en,
    output logic [HW-1:0] flags,
    output logic          sect_load,
    output logic [HW-1:0] sect_val,
    output logic          muuo,
    output logic          halt_req
);
    unit_state_t st_q, st_d;
    logic [HW-1:0] merged;
    logic do_restore, do_clr_pub, do_halt, illegal;

    flag_merge u_merge (
        .cur      (st_q.flags),
        .proposed (new_lh),
        .merged   (merged)
    );

    variant_decode u_dec (
        .op         (op),
        .cur_user   (st_q.flags[BIT_USER]),
        .cur_uio    (st_q.flags[BIT_UIO]),
        .cur_pub    (st_q.flags[BIT_PUB]),
        .do_restore (do_restore),
        .do_clr_pub (do_clr_pub),
        .do_halt    (do_halt),
        .illegal    (illegal)
    );

    always_comb begin
        st_d           = st_q;
        st_d.sect_load = 1'b0;
        st_d.muuo      = 1'b0;
        st_d.halt_req  = 1'b0;
        if (start) begin
            if (illegal) begin
                st_d.muuo = 1'b1;
            end else if (do_halt) begin
                st_d.halt_req = 1'b1;
            end else if (do_restore) begin
                st_d.flags = merged;
                if (sect_en && !merged[BIT_USER]) begin
                    st_d.sect_load = 1'b1;
                    st_d.sect_val  = new_rh & SECT_MASK;
                end
            end else if (do_clr_pub) begin
                st_d.flags[BIT_PUB] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags     = st_q.flags;
    assign sect_load = st_q.sect_load;
    assign sect_val  = st_q.sect_val;
    assign muuo      = st_q.muuo;
    assign halt_req  = st_q.halt_req;
endmodule

// File: rtl/flag_restore_chk.sv
module flag_restore_chk
    import flag_restore_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [3:0]    op,
    input logic [HW-1:0] new_lh,
    input logic [HW-1:0] new_rh,
    input logic          sect_en,
    input logic [HW-1:0] flags,
    input logic          sect_load,
    input logic [HW-1:0] sect_val,
    input logic          muuo,
    input logic          halt_req
);
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(flags) && !sect_load && !muuo && !halt_req));

    assert_user_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flags[BIT_USER] |=> flags[BIT_USER]);

    assert_exec_verbatim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 4'd2 && !flags[BIT_USER] && !flags[BIT_PUB])
        |=> flags == ($past(new_lh) & IMPL_MASK));

    assert_sect_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sect_load |-> (!flags[BIT_USER] && $past(sect_en) && $past(start)
                       && sect_val == ($past(new_rh) & SECT_MASK)));

    assert_muuo_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        muuo |-> $stable(flags));

    assert_halt_priv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (!$past(flags[BIT_USER]) && !$past(flags[BIT_PUB])
                      && $past(op) == 4'd4));

    assert_one_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sect_load, muuo, halt_req}));
endmodule

bind flag_restore_unit flag_restore_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .new_lh    (new_lh),
    .new_rh    (new_rh),
    .sect_en   (sect_en),
    .flags     (flags),
    .sect_load (sect_load),
    .sect_val  (sect_val),
    .muuo      (muuo),
    .halt_req  (halt_req)
);

// File: tb/flag_restore_unit_tb.sv
module flag_restore_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [17:0] new_lh = '0;
    logic [17:0] new_rh = '0;
    logic        sect_en = 1'b0;
    logic [17:0] flags;
    logic        sect_load;
    logic [17:0] sect_val;
    logic        muuo;
    logic        halt_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flag_restore_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .new_lh(new_lh), .new_rh(new_rh), .sect_en(sect_en),
        .flags(flags), .sect_load(sect_load), .sect_val(sect_val),
        .muuo(muuo), .halt_req(halt_req)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [17:0] lh;
        logic [17:0] rh;
        logic        se;
        logic [17:0] ef;
        logic        em;
        logic        eh;
        logic        es;
        logic [17:0] ev;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  18'h00C00, 18'h0, 1'b0, 18'h00C00, 1'b0, 1'b0, 1'b0, 18'h0},  // exec restore
        '{4'd8,  18'h0,     18'h0, 1'b0, 18'h00C00, 1'b1, 1'b0, 1'b0, 18'h0},  // R8 exec+pub
        '{4'd4,  18'h0,     18'h0, 1'b0, 18'h00C00, 1'b1, 1'b0, 1'b0, 18'h0},  // R9 pub halt
        '{4'd2,  18'h0,     18'h0, 1'b0, 18'h00400, 1'b0, 1'b0, 1'b0, 18'h0},  // R5 pub kept
        '{4'd1,  18'h3FFFF, 18'h0, 1'b0, 18'h00000, 1'b0, 1'b0, 1'b0, 18'h0},  // R11 portal
        '{4'd4,  18'h0,     18'h0, 1'b0, 18'h00000, 1'b0, 1'b1, 1'b0, 18'h0},  // R9 halt ok
        '{4'd5,  18'h00020, 18'h0013F, 1'b1, 18'h00020, 1'b0, 1'b0, 1'b1, 18'h0001F}, // R7
        '{4'd2,  18'h0141F, 18'h0, 1'b0, 18'h01400, 1'b0, 1'b0, 1'b0, 18'h0},  // R6 mask
        '{4'd5,  18'h00800, 18'h5, 1'b1, 18'h01400, 1'b0, 1'b0, 1'b0, 18'h0},  // R3 R4 R5
        '{4'd10, 18'h0,     18'h0, 1'b0, 18'h01400, 1'b1, 1'b0, 1'b0, 18'h0},  // R8 user
        '{4'd4,  18'h0,     18'h0, 1'b0, 18'h01400, 1'b1, 1'b0, 1'b0, 18'h0},  // R9 user
        '{4'd3,  18'h0,     18'h0, 1'b0, 18'h01400, 1'b1, 1'b0, 1'b0, 18'h0},  // R10
        '{4'd11, 18'h0,     18'h0, 1'b0, 18'h01400, 1'b1, 1'b0, 1'b0, 18'h0},  // R10
        '{4'd15, 18'h0,     18'h0, 1'b0, 18'h01400, 1'b1, 1'b0, 1'b0, 18'h0},  // R10
        '{4'd0,  18'h0,     18'h0, 1'b0, 18'h01400, 1'b0, 1'b0, 1'b0, 18'h0},  // R11
        '{4'd12, 18'h3FFFF, 18'h0, 1'b1, 18'h01400, 1'b0, 1'b0, 1'b0, 18'h0}   // R11
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] o, input logic [17:0] lh,
                         input logic [17:0] rh, input logic se);
        @(negedge clk);
        op = o; new_lh = lh; new_rh = rh; sect_en = se; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 flags", flags, 0);
        check("R1 pulses", {sect_load, muuo, halt_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after release", {flags, sect_load, muuo, halt_req}, 0);

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].op, TBL[i].lh, TBL[i].rh, TBL[i].se);
            check($sformatf("vec%0d flags R3 R4 R5 R6", i), flags, TBL[i].ef);
            check($sformatf("vec%0d muuo R8 R9 R10", i), muuo, TBL[i].em);
            check($sformatf("vec%0d halt R9", i), halt_req, TBL[i].eh);
            check($sformatf("vec%0d sect R7", i), sect_load, TBL[i].es);
            if (TBL[i].es) check($sformatf("vec%0d sect_val R7", i), sect_val, TBL[i].ev);
        end

        // R2: idle hold, pulses gone
        repeat (4) @(negedge clk);
        check("R2 hold flags", flags, 18'h01400);
        check("R2 pulses low", {sect_load, muuo, halt_req}, 0);

        // R4: user mode with user-I/O already set
        do_reset();
        issue(4'd2, 18'h01800, 18'h0, 1'b0);
        check("R3 enter user", flags, 18'h01800);
        issue(4'd10, 18'h00800, 18'h0, 1'b0);
        check("R8 legal with uio muuo", muuo, 1'b0);
        check("R4 uio kept", flags, 18'h01800);
        issue(4'd2, 18'h00000, 18'h0, 1'b0);
        check("R4 uio clear", flags, 18'h01000);

        // R5: exec to user clears public
        do_reset();
        check("R1 reset again", flags, 18'h0);
        issue(4'd2, 18'h00400, 18'h0, 1'b0);
        issue(4'd2, 18'h01000, 18'h0, 1'b0);
        check("R5 pub cleared on exec to user", flags, 18'h01000);

        // R7: sect_en off means no load
        do_reset();
        issue(4'd5, 18'h00020, 18'h0001F, 1'b0);
        check("R7 no load without enable", sect_load, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule